// File: doc/BRIEF.md
# Pipelined Memory-Mapped Read Master

This block fetches a contiguous region of memory over a memory-mapped bus and hands the words to a local consumer. A controller supplies a byte start address and a byte length, then pulses `go_i` while `done_o` is high. The master then issues one word read per accepted bus cycle. The bus may hold a request with `bus_wait_i`, and it may return data any number of cycles later on `bus_rvalid_i`. Several reads may be outstanding at the same time.

Returning words go into an internal first-in first-out buffer. The consumer drains the buffer through a show-ahead port at its own pace. The master counts the reads still in flight and adds the words already buffered. It withholds its request in the same cycle that this sum reaches the buffer depth minus a safety margin. A stalled consumer therefore makes the master pause without any stray request. A stray request could keep a shared arbiter's grant alive.

Top module: `bmr_read_master`

## Requirements
- R1: A synchronous reset empties the buffer, clears the in-flight count, drives `bus_read_o` low and `usr_valid_o` low, and drives `done_o` high.
- R2: `go_i` is taken only in a cycle where `done_o` is high, and `done_o` is low in the next cycle. A `go_i` pulse while `done_o` is low changes neither the address sequence nor the number of reads.
- R3: `done_o` rises one cycle after the first cycle in which no words remain to request and no read is in flight. A zero length completes this way with no bus read. `bus_read_o` is low whenever `done_o` is high.
- R4: The first read targets the start address, and each accepted read moves the next address up by 4 bytes (one 32-bit word). A transfer of L bytes, with L a multiple of 4, issues exactly L/4 accepted reads.
- R5: A read is accepted only when `bus_read_o` is high and `bus_wait_i` is low. While a request waits, `bus_read_o` stays high and `bus_addr_o` holds its value in the next cycle.
- R6: In any cycle with words left to request, `bus_read_o` is high exactly when buffered words plus in-flight reads are below 28 (depth 32 minus margin 4). The decision is combinational in that same cycle.
- R7: Buffered words plus in-flight reads never exceed 28, so the buffer is never written while full.
- R8: The in-flight count rises by one per accepted read and falls by one per `bus_rvalid_i`. Both may occur in the same cycle.
- R9: `usr_valid_o` is high exactly when the buffer holds a word. `usr_data_o` shows the oldest word, and words leave in bus-return order. `usr_ack_i` removes one word per cycle and has no effect on an empty buffer.
- R10: While the consumer stops acknowledging, the master fills up to the limit of R6 and then holds `bus_read_o` low until space returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start request, taken when `done_o` is high |
| start_addr_i | input | 32 | Byte address of the first word |
| length_i | input | 32 | Transfer length in bytes |
| done_o | output | 1 | High when idle and all data has returned |
| bus_addr_o | output | 32 | Byte address of the current request |
| bus_read_o | output | 1 | Read request |
| bus_wait_i | input | 1 | Bus stall; the request is not taken while high |
| bus_rdata_i | input | 32 | Returned read data |
| bus_rvalid_i | input | 1 | Returned data valid strobe |
| usr_data_o | output | 32 | Oldest buffered word |
| usr_valid_o | output | 1 | Buffer non-empty |
| usr_ack_i | input | 1 | Remove the oldest word |

## Verification
The assertions rely on the bus delivering exactly one `bus_rvalid_i` strobe per accepted read, never before the cycle after acceptance. They also rely on the length being a multiple of the word size. The bench bus model follows these rules by queuing each accepted address and returning it only from a later cycle, in order, with random gaps. Transfer lengths are drawn in whole words. Within those limits the stimulus varies stall density, return spacing and consumer pacing freely, and it adds a long consumer stall, a zero-length transfer and `go_i` pulses during busy transfers.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_RUN  = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/bmr_fifo.sv
module bmr_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             nonempty_o,
    output logic [CNT_W-1:0] level_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push_i && (st_q.level != CNT_W'(DEPTH));
        do_pop  = pop_i && (st_q.level != '0);
        st_d    = st_q;
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.level = st_q.level + 1'b1;
            2'b01:   st_d.level = st_q.level - 1'b1;
            default: st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data_i;
    end

    assign data_o     = mem_q[st_q.rd];
    assign nonempty_o = (st_q.level != '0);
    assign level_o    = st_q.level;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (st_q.level < CNT_W'(DEPTH)));

    // R9
    level_move_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && st_q.level != '0) |=> (st_q.level == $past(st_q.level) - 1'b1));

endmodule

// File: rtl/bmr_credit.sv
module bmr_credit #(
    parameter int DEPTH  = 32,
    parameter int MARGIN = 4,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             return_i,
    input  logic [CNT_W-1:0] level_i,
    output logic [CNT_W-1:0] pending_o,
    output logic             room_o
);
    localparam int LIMIT = DEPTH - MARGIN;
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] pending;
    } credit_st_t;

    credit_st_t st_d, st_q;
    logic [SUM_W-1:0] occupancy;

    always_comb begin
        occupancy = {1'b0, level_i} + {1'b0, st_q.pending};
        // Same-cycle gate: no registered copy of this comparison exists.
        room_o    = (occupancy < SUM_W'(LIMIT));
        st_d      = st_q;
        case ({accept_i, return_i})
            2'b10:   st_d.pending = st_q.pending + 1'b1;
            2'b01:   st_d.pending = st_q.pending - 1'b1;
            default: st_d.pending = st_q.pending;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pending_o = st_q.pending;

    // R8
    pending_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        return_i |-> (st_q.pending != '0));

    // R7
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= SUM_W'(LIMIT));

    // R6
    accept_has_room_chk: assert property (@(posedge clk) disable iff (rst)
        accept_i |-> (occupancy < SUM_W'(LIMIT)));

endmodule

// File: rtl/bmr_issue.sv
module bmr_issue
    import bmr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  length_i,
    input  logic              room_i,
    input  logic              pending_zero_i,
    input  logic              waitreq_i,
    output logic              read_o,
    output logic [ADDR_W-1:0] address_o,
    output logic              accept_o,
    output logic              done_o
);
    typedef struct packed {
        xfer_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } issue_st_t;

    issue_st_t st_d, st_q;
    logic words_left;

    always_comb begin
        words_left = (st_q.remain >= LEN_W'(WORD_BYTES));
        read_o     = (st_q.state == XF_RUN) && words_left && room_i;
        accept_o   = read_o && !waitreq_i;
        st_d       = st_q;
        case (st_q.state)
            XF_IDLE: begin
                if (go_i) begin
                    st_d.state  = XF_RUN;
                    st_d.addr   = start_addr_i;
                    st_d.remain = length_i;
                end
            end
            default: begin
                if (accept_o) begin
                    st_d.addr   = st_q.addr + ADDR_W'(WORD_BYTES);
                    st_d.remain = st_q.remain - LEN_W'(WORD_BYTES);
                end
                if (!words_left && pending_zero_i) st_d.state = XF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state  <= XF_IDLE;
            st_q.addr   <= '0;
            st_q.remain <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign address_o = st_q.addr;
    assign done_o    = (st_q.state == XF_IDLE);

    // R5
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (read_o && waitreq_i) |=> (read_o && $stable(address_o)));

    // R2
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (go_i && done_o) |=> !done_o);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !read_o);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (accept_o && !done_o) |=> (address_o == $past(address_o) + ADDR_W'(WORD_BYTES)));

endmodule

// File: rtl/bmr_read_master.sv
module bmr_read_master #(
    parameter int ADDR_W        = 32,
    parameter int DATA_W        = 32,
    parameter int LEN_W         = 32,
    parameter int FIFO_DEPTH    = 32,
    parameter int SAFETY_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  length_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_read_o,
    input  logic              bus_wait_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_rvalid_i,
    output logic [DATA_W-1:0] usr_data_o,
    output logic              usr_valid_o,
    input  logic              usr_ack_i
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    logic [CNT_W-1:0] fill_level;
    logic [CNT_W-1:0] in_flight;
    logic             room;
    logic             accept;

    bmr_issue #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .WORD_BYTES(WORD_BYTES)
    ) issue_i (
        .clk           (clk),
        .rst           (rst),
        .go_i          (go_i),
        .start_addr_i  (start_addr_i),
        .length_i      (length_i),
        .room_i        (room),
        .pending_zero_i(in_flight == '0),
        .waitreq_i     (bus_wait_i),
        .read_o        (bus_read_o),
        .address_o     (bus_addr_o),
        .accept_o      (accept),
        .done_o        (done_o)
    );

    bmr_credit #(
        .DEPTH (FIFO_DEPTH),
        .MARGIN(SAFETY_MARGIN),
        .CNT_W (CNT_W)
    ) credit_i (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .return_i (bus_rvalid_i),
        .level_i  (fill_level),
        .pending_o(in_flight),
        .room_o   (room)
    );

    bmr_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(FIFO_DEPTH),
        .CNT_W(CNT_W)
    ) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .push_i     (bus_rvalid_i),
        .push_data_i(bus_rdata_i),
        .pop_i      (usr_ack_i),
        .data_o     (usr_data_o),
        .nonempty_o (usr_valid_o),
        .level_o    (fill_level)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (done_o && !usr_valid_o && !bus_read_o));

endmodule

// File: tb/bmr_read_master_tb_top.sv
module bmr_read_master_tb_top;

    localparam int LIMIT = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [31:0] start_addr = '0;
    logic [31:0] length = '0;
    logic        done;
    logic [31:0] bus_addr;
    logic        bus_read;
    logic        bus_wait = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_rvalid = 1'b0;
    logic [31:0] usr_data;
    logic        usr_valid;
    logic        usr_ack = 1'b0;

    always #5 clk = ~clk;

    bmr_read_master dut_i (
        .clk         (clk),
        .rst         (rst),
        .go_i        (go),
        .start_addr_i(start_addr),
        .length_i    (length),
        .done_o      (done),
        .bus_addr_o  (bus_addr),
        .bus_read_o  (bus_read),
        .bus_wait_i  (bus_wait),
        .bus_rdata_i (bus_rdata),
        .bus_rvalid_i(bus_rvalid),
        .usr_data_o  (usr_data),
        .usr_valid_o (usr_valid),
        .usr_ack_i   (usr_ack)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // bench model state
    int          bfifo = 0;
    int          outstanding = 0;
    int          left = 0;
    int          popped = 0;
    logic [31:0] issue_addr = '0;
    logic [31:0] pop_addr = '0;
    logic [31:0] rq[$];
    int          wait_pct = 0;
    int          resp_pct = 100;
    int          ack_pct = 100;
    bit          start_req = 0;
    bit          active_b = 0;
    bit          first_b = 0;
    bit          cond_prev = 0;
    bit          inject_go = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic bit roll(input int pct);
        return ($urandom_range(99, 0) < pct);
    endfunction

    // Bus model, consumer model and cycle checks, all on the falling edge.
    initial begin
        bit exp_read;
        bit cond_now;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (go && start_req && !active_b) begin
                    go = 1'b0;
                    start_req = 0;
                    active_b = 1;
                    first_b = 1;
                end else if (go) begin
                    go = 1'b0;
                end

                if (active_b) begin
                    if (first_b) begin
                        chk(done == 1'b0, "R2 done low after go", done, 0);
                        first_b = 0;
                    end else begin
                        chk(done == cond_prev, "R3 done timing", done, cond_prev);
                        if (done) active_b = 0;
                    end
                end

                if (active_b) begin
                    exp_read = (left > 0) && ((bfifo + outstanding) < LIMIT);
                    chk(bus_read == exp_read, "R6 same-cycle throttle", bus_read, exp_read);
                    if (bus_read)
                        chk(bus_addr == issue_addr, "R4 address sequence", bus_addr, issue_addr);
                    if (prev_stall)
                        chk(bus_read && bus_addr == prev_addr, "R5 held while waiting", bus_addr, prev_addr);
                end else begin
                    chk(bus_read == 1'b0, "R3 no read when done", bus_read, 0);
                end
                chk((bfifo + outstanding) <= LIMIT, "R7 occupancy bound", bfifo + outstanding, LIMIT);
                chk(usr_valid == (bfifo > 0), "R9 valid flag", usr_valid, bfifo > 0);
                cond_now = (left == 0) && (outstanding == 0);
                cond_prev = cond_now;

                // consumer (ack on an empty buffer is allowed and must do nothing)
                usr_ack = roll(ack_pct);
                if (usr_valid && usr_ack) begin
                    chk(usr_data == mem_fn(pop_addr), "R9 data order", usr_data, mem_fn(pop_addr));
                    pop_addr = pop_addr + 32'd4;
                    popped++;
                    bfifo--;
                end

                // returns from earlier accepted reads, in order
                if (rq.size() > 0 && roll(resp_pct)) begin
                    bus_rvalid = 1'b1;
                    bus_rdata = mem_fn(rq.pop_front());
                    outstanding--;
                    bfifo++;
                end else begin
                    bus_rvalid = 1'b0;
                    bus_rdata = $urandom;
                end

                bus_wait = roll(wait_pct);
                prev_stall = bus_read && bus_wait && active_b;
                prev_addr = bus_addr;
                if (bus_read && !bus_wait) begin
                    rq.push_back(issue_addr);
                    issue_addr = issue_addr + 32'd4;
                    left--;
                    outstanding++;
                end

                if (inject_go && active_b && !done && !first_b) begin
                    go = 1'b1;
                    start_addr = $urandom;
                    length = $urandom_range(400, 4) & ~32'd3;
                    inject_go = 0;
                end else if (start_req && !active_b && done && !go) begin
                    go = 1'b1;
                    start_addr = req_addr;
                    length = req_len;
                    left = int'(req_len >> 2);
                    issue_addr = req_addr;
                    pop_addr = req_addr;
                    popped = 0;
                end
            end
        end
    end

    task automatic launch(input logic [31:0] a, input int words, input int wp, input int rp,
                          input int ap, input bit inj);
        wait_pct = wp;
        resp_pct = rp;
        ack_pct = ap;
        req_addr = a & ~32'd3;
        req_len = 32'(words) << 2;
        inject_go = inj;
        start_req = 1;
    endtask

    task automatic finish_xfer(input int words, input string tag);
        while (start_req || active_b || bfifo > 0) @(posedge clk);
        chk(popped == words, tag, popped, words);
        chk(left == 0 && outstanding == 0, "R4 all words requested", left, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #2;
        // R1 reset state
        chk(done == 1'b1, "R1 done after reset", done, 1);
        chk(bus_read == 1'b0, "R1 read after reset", bus_read, 0);
        chk(usr_valid == 1'b0, "R1 valid after reset", usr_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);

        // R3 zero length
        launch(32'h0000_1000, 0, 0, 100, 100, 0);
        finish_xfer(0, "R3 zero length words");

        // R4 short clean burst
        launch(32'h0000_2000, 8, 0, 100, 100, 0);
        finish_xfer(8, "R4 eight words");

        // R5 heavy waitrequest
        launch(32'hFFFF_FFF0, 12, 80, 60, 100, 0);
        finish_xfer(12, "R5 wrap with stalls");

        // R10 consumer stall fills to the limit and pauses
        launch(32'h0001_0000, 64, 0, 100, 0, 0);
        repeat (120) @(posedge clk);
        #2;
        chk(bfifo == LIMIT, "R10 filled to limit", bfifo, LIMIT);
        chk(bus_read == 1'b0, "R10 paused on stall", bus_read, 0);
        chk(done == 1'b0, "R10 still busy", done, 0);
        ack_pct = 100;
        finish_xfer(64, "R10 resumed transfer");

        // R2 go while busy must be ignored
        launch(32'h0002_0000, 40, 30, 50, 70, 1);
        finish_xfer(40, "R2 busy go ignored");

        // R8 random mixes
        for (int i = 0; i < 25; i++) begin
            launch($urandom, $urandom_range(90, 0), $urandom_range(70, 0),
                   $urandom_range(100, 20), $urandom_range(100, 10), (i % 4) == 1);
            finish_xfer(int'(req_len >> 2), "R8 random transfer words");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule